// File: doc/BRIEF.md
# Power-Fail Autostore and Recall Sequencer

This block sequences the nonvolatile side of a battery-free backed static memory. Two digital flags arrive from external supply comparators. One says the supply is under the switch threshold, where the memory must stop taking writes and save itself. The other says it is under the lower reset threshold, where the volatile contents can no longer be trusted. When the supply first falls past the switch level, the sequencer launches a store into the nonvolatile image. It does this only if a write has landed since the last store or recall, and only if the autostore strap is not set. When the supply comes back above the switch level after a deep drop, it launches a recall.

Software can request a store or a recall directly while the supply is healthy and the sequencer is idle. A store always runs on request. A recall first runs a clear phase and then a load phase. While any cycle runs, the block raises a busy flag that shuts out host access. A write-inhibit output blocks writes whenever the supply is low or the sequencer is not idle. Cycle lengths are counts of clock cycles set by parameters.

Top module: `powerfail_store_ctrl`

## Requirements
- R1: In the idle state, when `belowSwitch` is high, at least one accepted write has happened since the last store or recall start, and `autoInhibit` is low, a store begins on the next clock edge.
- R2: When no write has been accepted since the most recent store or recall start, a low supply moves the sequencer to its low-supply wait with no store. A software store request runs even when nothing was written.
- R3: Any cycle in which `belowReset` is high latches a pending recall. Once `belowSwitch` is low again, the sequencer (in its low-supply wait) starts the recall on the next edge.
- R4: A dip below the switch level that never reaches the reset level is followed by a return to idle with no recall.
- R5: `writeInhibit` is high whenever `belowSwitch` is high or the sequencer is not idle. A write strobe seen while `writeInhibit` is high does not count as a write. Software requests are ignored while `belowSwitch` is high.
- R6: A store holds `busy` high for exactly STORE_CYCLES cycles. `storeStart` is a one-cycle pulse in the first of them. The sequencer then passes through the low-supply wait.
- R7: A recall holds `busy` high for exactly RECALL_CYCLES cycles. `recallStart` pulses in the first cycle, which begins the clear phase. `loadStart` pulses CLEAR_CYCLES cycles later, when the load phase begins. Afterwards the sequencer is idle.
- R8: With `autoInhibit` high, a low supply never starts a store, even after writes. Software requests still work.
- R9: Software requests that arrive while `busy` is high are ignored. When both requests arrive together in idle, the store wins.
- R10: Reset clears the written flag, sets a pending recall and puts the sequencer in the low-supply wait. With the supply healthy, the recall therefore starts at the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| belowSwitch | input | 1 | Supply under switch threshold |
| belowReset | input | 1 | Supply under reset threshold |
| writeStrobe | input | 1 | A host write completes this cycle |
| swStoreReq | input | 1 | Software store request |
| swRecallReq | input | 1 | Software recall request |
| autoInhibit | input | 1 | Strap: disable automatic store |
| storeStart | output | 1 | Pulse: store engine start |
| recallStart | output | 1 | Pulse: recall clear phase start |
| loadStart | output | 1 | Pulse: recall load phase start |
| busy | output | 1 | Nonvolatile cycle in progress |
| writeInhibit | output | 1 | Host writes blocked |

## Verification
The bench targets these corner cases:
- A write made during a store. A design that counted it would fire a second, needless autostore at the next dip.
- A shallow dip versus a deep one. A design that skipped the pending latch would either recall after every dip or never recover after a real brown-out.
- Software requests issued during a cycle or under a low supply. A design that honoured them would stretch `busy` or store while power is failing.
- The strap. A design that ignored it would still store automatically.
- Busy counted to the cycle and the phase boundary of the recall. This exposes off-by-one timer loads.
- Reset, both with the supply held low and in the middle of a store. This shows that the recall waits for the supply and that reset aborts a running store.

// File: rtl/pfsc_pkg.sv
package pfsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_STORE,
    ST_RCLR,
    ST_RLOAD
  } ctrlState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadStore;
    logic loadClear;
    logic loadFill;
    logic countDown;
    logic clearDirty;
    logic clearPending;
  } dpStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic timerZero;
    logic dirty;
    logic pending;
  } dpStatus_t;

endpackage

// File: rtl/pfsc_datapath.sv
module pfsc_datapath
  import pfsc_pkg::*;
#(
  parameter int STORE_CYCLES  = 1000000,
  parameter int RECALL_CYCLES = 55000,
  parameter int CLEAR_CYCLES  = 1000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      belowReset,
  input  logic      writeStrobe,
  input  logic      writeInhibit,
  input  dpStrobe_t strb,
  output dpStatus_t stat
);

  localparam int MAXC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] STORE_LOAD = TW'(STORE_CYCLES - 1);
  localparam logic [TW-1:0] CLEAR_LOAD = TW'(CLEAR_CYCLES - 1);
  localparam logic [TW-1:0] FILL_LOAD  = TW'(RECALL_CYCLES - CLEAR_CYCLES - 1);

  logic [TW-1:0] timer;
  logic          dirty;
  logic          pending;
  logic          writeAccepted;

  assign writeAccepted = writeStrobe && !writeInhibit;

  // phase timer: loads win over counting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
    end else if (strb.loadStore) begin
      timer <= STORE_LOAD;
    end else if (strb.loadClear) begin
      timer <= CLEAR_LOAD;
    end else if (strb.loadFill) begin
      timer <= FILL_LOAD;
    end else if (strb.countDown && (timer != '0)) begin
      timer <= timer - 1'b1;
    end
  end

  // written-since-last-cycle flag: clearing beats setting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= 1'b0;
    end else if (strb.clearDirty) begin
      dirty <= 1'b0;
    end else if (writeAccepted) begin
      dirty <= 1'b1;
    end
  end

  // recall request latch: a deep drop always wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b1;
    end else if (belowReset) begin
      pending <= 1'b1;
    end else if (strb.clearPending) begin
      pending <= 1'b0;
    end
  end

  assign stat.timerZero = (timer == '0);
  assign stat.dirty     = dirty;
  assign stat.pending   = pending;

endmodule

// File: rtl/pfsc_control.sv
module pfsc_control
  import pfsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      belowSwitch,
  input  logic      swStoreReq,
  input  logic      swRecallReq,
  input  logic      autoInhibit,
  input  dpStatus_t stat,
  output dpStrobe_t strb,
  output logic      storeStart,
  output logic      recallStart,
  output logic      loadStart,
  output logic      busy,
  output logic      writeInhibit
);

  ctrlState_t st;
  ctrlState_t nextSt;
  logic       goStore;
  logic       goRecall;
  logic       goFill;

  always_comb begin
    nextSt   = st;
    goStore  = 1'b0;
    goRecall = 1'b0;
    goFill   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (belowSwitch) begin
          if (!autoInhibit && stat.dirty) begin
            goStore = 1'b1;
            nextSt  = ST_STORE;
          end else begin
            nextSt = ST_LOW;
          end
        end else if (swStoreReq) begin
          goStore = 1'b1;
          nextSt  = ST_STORE;
        end else if (swRecallReq) begin
          goRecall = 1'b1;
          nextSt   = ST_RCLR;
        end
      end
      ST_LOW: begin
        if (!belowSwitch) begin
          if (stat.pending) begin
            goRecall = 1'b1;
            nextSt   = ST_RCLR;
          end else begin
            nextSt = ST_IDLE;
          end
        end
      end
      ST_STORE: begin
        if (stat.timerZero) nextSt = ST_LOW;
      end
      ST_RCLR: begin
        if (stat.timerZero) begin
          goFill = 1'b1;
          nextSt = ST_RLOAD;
        end
      end
      ST_RLOAD: begin
        if (stat.timerZero) nextSt = ST_IDLE;
      end
      default: nextSt = ST_LOW;
    endcase
  end

  assign busy         = (st == ST_STORE) || (st == ST_RCLR) || (st == ST_RLOAD);
  assign writeInhibit = belowSwitch || (st != ST_IDLE);

  always_comb begin
    strb              = '0;
    strb.loadStore    = goStore;
    strb.loadClear    = goRecall;
    strb.loadFill     = goFill;
    strb.countDown    = busy;
    strb.clearDirty   = goStore || goRecall;
    strb.clearPending = goRecall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_LOW;
      storeStart  <= 1'b0;
      recallStart <= 1'b0;
      loadStart   <= 1'b0;
    end else begin
      st          <= nextSt;
      storeStart  <= goStore;
      recallStart <= goRecall;
      loadStart   <= goFill;
    end
  end

endmodule

// File: rtl/powerfail_store_ctrl.sv
module powerfail_store_ctrl
  import pfsc_pkg::*;
#(
  parameter int STORE_CYCLES  = 1000000,
  parameter int RECALL_CYCLES = 55000,
  parameter int CLEAR_CYCLES  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic belowSwitch,
  input  logic belowReset,
  input  logic writeStrobe,
  input  logic swStoreReq,
  input  logic swRecallReq,
  input  logic autoInhibit,
  output logic storeStart,
  output logic recallStart,
  output logic loadStart,
  output logic busy,
  output logic writeInhibit
);

  dpStrobe_t strb;
  dpStatus_t stat;

  pfsc_control u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .belowSwitch  (belowSwitch),
    .swStoreReq   (swStoreReq),
    .swRecallReq  (swRecallReq),
    .autoInhibit  (autoInhibit),
    .stat         (stat),
    .strb         (strb),
    .storeStart   (storeStart),
    .recallStart  (recallStart),
    .loadStart    (loadStart),
    .busy         (busy),
    .writeInhibit (writeInhibit)
  );

  pfsc_datapath #(
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES),
    .CLEAR_CYCLES  (CLEAR_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .belowReset   (belowReset),
    .writeStrobe  (writeStrobe),
    .writeInhibit (writeInhibit),
    .strb         (strb),
    .stat         (stat)
  );

endmodule

// File: rtl/pfsc_checker.sv
module pfsc_checker #(
  parameter int STORE_CYCLES  = 1000000,
  parameter int RECALL_CYCLES = 55000
) (
  input logic clk,
  input logic rst_n,
  input logic belowSwitch,
  input logic storeStart,
  input logic recallStart,
  input logic loadStart,
  input logic busy,
  input logic writeInhibit
);

  localparam int LIMIT = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CW    = $clog2(LIMIT + 1) + 1;

  logic [CW-1:0] busyRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  // R5: a low supply always blocks writes
  a_r5_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    belowSwitch |-> writeInhibit);

  // R5: a running cycle always blocks writes
  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> writeInhibit);

  // R6: store start is a single-cycle pulse inside busy
  a_r6_store_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    storeStart |=> !storeStart);

  a_r6_store_busy: assert property (@(posedge clk) disable iff (!rst_n)
    storeStart |-> busy);

  // R6, R7: no busy run exceeds the longest cycle length
  a_r6_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busyRun < CW'(LIMIT)));

  // R7: recall start lies inside busy; load start follows an earlier busy cycle
  a_r7_recall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    recallStart |-> busy);

  a_r7_load_inside: assert property (@(posedge clk) disable iff (!rst_n)
    loadStart |-> (busy && $past(busy)));

  // R7: busy only rises together with a start pulse
  a_r7_rise_started: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (storeStart || recallStart));

  // R9: at most one engine start per cycle
  a_r9_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({storeStart, recallStart, loadStart}));

endmodule

bind powerfail_store_ctrl pfsc_checker #(
  .STORE_CYCLES  (STORE_CYCLES),
  .RECALL_CYCLES (RECALL_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .belowSwitch  (belowSwitch),
  .storeStart   (storeStart),
  .recallStart  (recallStart),
  .loadStart    (loadStart),
  .busy         (busy),
  .writeInhibit (writeInhibit)
);

// File: tb/powerfail_store_ctrl_tb.sv
module powerfail_store_ctrl_tb;

  localparam int SC = 4;
  localparam int RC = 5;
  localparam int CC = 2;
  localparam int NV = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic belowSwitch = 1'b0, belowReset = 1'b0, writeStrobe = 1'b0;
  logic swStoreReq = 1'b0, swRecallReq = 1'b0, autoInhibit = 1'b0;
  logic storeStart, recallStart, loadStart, busy, writeInhibit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  powerfail_store_ctrl #(
    .STORE_CYCLES (SC), .RECALL_CYCLES (RC), .CLEAR_CYCLES (CC)
  ) u_dut (
    .clk (clk), .rst_n (rst_n),
    .belowSwitch (belowSwitch), .belowReset (belowReset),
    .writeStrobe (writeStrobe), .swStoreReq (swStoreReq),
    .swRecallReq (swRecallReq), .autoInhibit (autoInhibit),
    .storeStart (storeStart), .recallStart (recallStart),
    .loadStart (loadStart), .busy (busy), .writeInhibit (writeInhibit)
  );

  // {req[3:0], belowSwitch belowReset writeStrobe swStore swRecall autoInhibit,
  //  busy writeInhibit storeStart recallStart loadStart}
  localparam logic [14:0] VEC [NV] = '{
    {4'd10, 6'b000000, 5'b11010},  // R10 recall right after reset
    {4'd7,  6'b000000, 5'b11000},  // R7 clear phase
    {4'd7,  6'b000000, 5'b11001},  // R7 load phase begins
    {4'd7,  6'b000000, 5'b11000},
    {4'd7,  6'b000000, 5'b11000},
    {4'd7,  6'b000000, 5'b00000},  // R7 idle after 5 busy cycles
    {4'd2,  6'b100000, 5'b01000},  // R2 dip, nothing written: no store
    {4'd4,  6'b100000, 5'b01000},
    {4'd4,  6'b000000, 5'b00000},  // R4 shallow dip: no recall
    {4'd1,  6'b001000, 5'b00000},  // R1 accepted write
    {4'd1,  6'b100000, 5'b11100},  // R1 autostore
    {4'd5,  6'b101000, 5'b11000},  // R5 write during store is blocked
    {4'd3,  6'b110000, 5'b11000},  // R3 deep drop latched
    {4'd6,  6'b100000, 5'b11000},
    {4'd6,  6'b100000, 5'b01000},  // R6 store over after 4 cycles
    {4'd3,  6'b000000, 5'b11010},  // R3 recall on return
    {4'd7,  6'b000000, 5'b11000},
    {4'd7,  6'b000000, 5'b11001},
    {4'd7,  6'b000000, 5'b11000},
    {4'd7,  6'b000000, 5'b11000},
    {4'd7,  6'b000000, 5'b00000},
    {4'd5,  6'b100000, 5'b01000},  // R5 blocked write left flag clear
    {4'd4,  6'b000000, 5'b00000},
    {4'd2,  6'b000100, 5'b11100},  // R2 software store with nothing written
    {4'd9,  6'b000010, 5'b11000},  // R9 recall request while busy
    {4'd6,  6'b000000, 5'b11000},
    {4'd6,  6'b000000, 5'b11000},
    {4'd6,  6'b000000, 5'b01000},
    {4'd9,  6'b000000, 5'b00000},  // R9 ignored request never ran
    {4'd8,  6'b001001, 5'b00000},  // R8 write with strap set
    {4'd8,  6'b100001, 5'b01000},  // R8 no autostore
    {4'd8,  6'b000001, 5'b00000},
    {4'd5,  6'b100101, 5'b01000},  // R5 software store ignored on low supply
    {4'd5,  6'b000001, 5'b00000},
    {4'd7,  6'b000011, 5'b11010},  // R7 software recall
    {4'd7,  6'b000001, 5'b11000},
    {4'd7,  6'b000001, 5'b11001},
    {4'd7,  6'b000001, 5'b11000},
    {4'd7,  6'b000001, 5'b11000},
    {4'd7,  6'b000001, 5'b00000},
    {4'd2,  6'b100000, 5'b01000},  // R2 recall cleared the flag
    {4'd4,  6'b000000, 5'b00000},
    {4'd9,  6'b000110, 5'b11100},  // R9 store beats recall
    {4'd9,  6'b000000, 5'b11000},
    {4'd9,  6'b000000, 5'b11000},
    {4'd9,  6'b000000, 5'b11000},
    {4'd9,  6'b000000, 5'b01000},
    {4'd9,  6'b000000, 5'b00000}
  };

  task automatic drive(input logic [5:0] v);
    {belowSwitch, belowReset, writeStrobe, swStoreReq, swRecallReq, autoInhibit} = v;
  endtask

  task automatic checkOut(input int req, input logic [4:0] exp, input string what);
    logic [4:0] got;
    got = {busy, writeInhibit, storeStart, recallStart, loadStart};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic checkVal(input int req, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    checkOut(10, 5'b01000, "reset state");  // R10
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10:5]);
      @(negedge clk);
      checkOut(int'(VEC[i][14:11]), VEC[i][4:0], $sformatf("table step %0d", i + 1));
    end

    // R6: store busy length measured directly
    drive(6'b000100);
    @(negedge clk);
    drive(6'b000000);
    n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); end
    checkVal(6, n, SC, "store busy cycles");
    repeat (2) @(negedge clk);

    // R7: recall busy length and load-phase offset
    drive(6'b000010);
    @(negedge clk);
    drive(6'b000000);
    n = 0;
    while (busy && n < 50) begin
      if (loadStart) checkVal(7, n, CC, "load phase offset");
      n++;
      @(negedge clk);
    end
    checkVal(7, n, RC, "recall busy cycles");

    // R10: reset aborts a running store
    drive(6'b000100);
    @(negedge clk);
    drive(6'b000000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    checkOut(10, 5'b01000, "reset during store");

    // R3, R10: reset with supply held low waits for recovery
    drive(6'b110000);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (recallStart || busy) n++;
    end
    checkVal(3, n, 0, "no recall while supply low");
    drive(6'b000000);
    @(negedge clk);
    checkOut(3, 5'b11010, "recall on supply return");
    repeat (RC + 1) @(negedge clk);
    checkOut(7, 5'b00000, "idle after recall");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule